// File: doc/BRIEF.md
# AMI Line Encoder with Test Fault Injection

This block turns a serial NRZ transmit stream into alternate mark inversion signalling on a positive and a negative rail. A bit is taken in each cycle where `bit_en` is high. A zero drives neither rail. Each one drives the rail opposite to the previous one. For each bit the selected rail stays asserted for the whole bit period, until the next `bit_en`.

Two test requests let software damage the line signal on purpose. A rising edge on `viol_req` arms one bipolar violation. The violation waits until the data holds three ones in a row. The middle one of that run is then sent with the same polarity as the one before it, and alternation carries on from that mark. A rising edge on `err_req` arms one logic error. The next data bit taken in is inverted before encoding. To find a run of three, the encoder must see one bit ahead, so every bit reaches the rails exactly two bit periods after it was taken in.

Each request passes through a small FSM with the states REQ_IDLE and REQ_ARMED. A rising edge moves it from REQ_IDLE to REQ_ARMED. It returns to REQ_IDLE on consume, when its event is applied. The mark-polarity FSM has the states LAST_NEG and LAST_POS. A normal mark takes the flip transition to the other state. A violating mark takes the hold transition and keeps the state. A zero leaves the state unchanged. Reset enters LAST_NEG, so the first mark after reset is positive.

Top module: `ami_violation_encoder`

## Requirements
- R1: A zero bit drives both rails low (`rail_pos`=0, `rail_neg`=0) for its bit period.
- R2: Without an armed violation, each one bit is sent with the polarity opposite to the previous mark. The first mark after reset is positive (`rail_pos`=1).
- R3: The bit taken in at bit-enable k drives the rails from the clock edge of bit-enable k+2 until the next bit-enable. The rails do not change in cycles where `bit_en` is low.
- R4: After a rising edge on `viol_req`, the encoder waits for the first bit that has a one before it and a one after it in the stream. That bit is sent with the same polarity as the one before it.
- R5: After a violation, alternation continues from the violating mark, so the next mark has the opposite polarity to it.
- R6: Each rising edge of `viol_req` yields exactly one violation. Holding `viol_req` high, or raising it again while a violation is already armed, yields no extra violation.
- R7: After a rising edge on `err_req`, the next bit taken in is inverted before encoding.
- R8: Each rising edge of `err_req` inverts exactly one bit. Holding `err_req` high inverts no further bits.
- R9: `rail_pos` and `rail_neg` are never high together.
- R10: After reset, both rails are low and no violation or error is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe that takes in one data bit |
| data_in | input | 1 | NRZ data bit, sampled when `bit_en` is high |
| viol_req | input | 1 | Violation request level; its rising edge arms one violation |
| err_req | input | 1 | Logic-error request level; its rising edge arms one bit inversion |
| rail_pos | output | 1 | Positive mark rail |
| rail_neg | output | 1 | Negative mark rail |

## Verification
The hardest case to reach is a violation request that has been armed for a long time. It must then fire at a run of three ones that starts while it is armed, possibly one that an injected error helped create. It must also not fire a second time when the request line stays high. The stimulus covers this by arming a violation during a stretch of zeros and sending isolated ones and pairs of ones before any triple. It then holds `viol_req` high across several runs of ones, and also flips a zero into a one with `err_req` to complete a run. Random data with sparse random requests then checks every bit period against a reference model written from the requirements.

// File: rtl/ami_pkg.sv
package ami_pkg;

    typedef enum logic {
        REQ_IDLE  = 1'b0,
        REQ_ARMED = 1'b1
    } req_state_t;

    typedef enum logic {
        LAST_NEG = 1'b0,
        LAST_POS = 1'b1
    } pol_state_t;

    localparam int unsigned WIN_LEN = 3;

endpackage

// File: rtl/oneshot_request.sv
module oneshot_request
    import ami_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic consume,
    output logic armed
);

    logic       req_q;
    logic       rise;
    req_state_t state_q;
    req_state_t state_d;

    assign rise = req & ~req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            state_q <= REQ_IDLE;
        end else begin
            req_q   <= req;
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:  if (rise) state_d = REQ_ARMED;
            REQ_ARMED: if (consume && !rise) state_d = REQ_IDLE;
            default:   state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == REQ_ARMED);
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && consume && !rise) |=> !armed); // R6

    AST_ARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !rise) |=> !armed); // R8

endmodule

// File: rtl/bit_window.sv
module bit_window
    import ami_pkg::*;
#(
    parameter int unsigned LEN = WIN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic next_bit,
    output logic cur_bit,
    output logic prev_bit
);

    localparam int unsigned LAST = LEN - 1;

    logic [LAST:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q[0] <= 1'b0;
        end else if (bit_en) begin
            win_q[0] <= bit_in;
        end
    end

    for (genvar g = 1; g < LEN; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q[g] <= 1'b0;
            end else if (bit_en) begin
                win_q[g] <= win_q[g-1];
            end
        end
    end

    assign next_bit = win_q[0];
    assign cur_bit  = win_q[1];
    assign prev_bit = win_q[LAST];

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(win_q)); // R3

endmodule

// File: rtl/ami_marker.sv
module ami_marker
    import ami_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic prev_bit,
    input  logic cur_bit,
    input  logic next_bit,
    input  logic viol_armed,
    output logic viol_fire,
    output logic rail_pos,
    output logic rail_neg
);

    pol_state_t pol_q;
    pol_state_t pol_d;
    logic       mark_pos;
    logic       pos_d;
    logic       neg_d;

    assign viol_fire = bit_en & viol_armed & prev_bit & cur_bit & next_bit;

    always_comb begin
        pol_d = pol_q;
        if (bit_en && cur_bit) begin
            unique case (pol_q)
                LAST_NEG: pol_d = viol_fire ? LAST_NEG : LAST_POS;
                LAST_POS: pol_d = viol_fire ? LAST_POS : LAST_NEG;
                default:  pol_d = LAST_NEG;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= LAST_NEG;
        else        pol_q <= pol_d;
    end

    always_comb begin
        mark_pos = (pol_d == LAST_POS);
        pos_d    = cur_bit & mark_pos;
        neg_d    = cur_bit & ~mark_pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_pos <= 1'b0;
            rail_neg <= 1'b0;
        end else if (bit_en) begin
            rail_pos <= pos_d;
            rail_neg <= neg_d;
        end
    end

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !cur_bit) |=> (!rail_pos && !rail_neg)); // R1

    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cur_bit && !viol_armed) |=> (pol_q != $past(pol_q))); // R2

    AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        viol_fire |=> (pol_q == $past(pol_q))); // R4

    AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_pos && rail_neg)); // R9

endmodule

// File: rtl/ami_violation_encoder.sv
module ami_violation_encoder
    import ami_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic data_in,
    input  logic viol_req,
    input  logic err_req,
    output logic rail_pos,
    output logic rail_neg
);

    logic err_armed;
    logic viol_armed;
    logic viol_fire;
    logic line_bit;
    logic next_bit;
    logic cur_bit;
    logic prev_bit;

    oneshot_request u_err_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (err_req),
        .consume (bit_en),
        .armed   (err_armed)
    );

    oneshot_request u_viol_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (viol_req),
        .consume (viol_fire),
        .armed   (viol_armed)
    );

    assign line_bit = data_in ^ err_armed;

    bit_window #(.LEN(WIN_LEN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (line_bit),
        .next_bit (next_bit),
        .cur_bit  (cur_bit),
        .prev_bit (prev_bit)
    );

    ami_marker u_marker (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .prev_bit   (prev_bit),
        .cur_bit    (cur_bit),
        .next_bit   (next_bit),
        .viol_armed (viol_armed),
        .viol_fire  (viol_fire),
        .rail_pos   (rail_pos),
        .rail_neg   (rail_neg)
    );

    AST_RAILS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(rail_pos) && $stable(rail_neg))); // R3

    AST_ERR_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && err_armed && !(err_req && !$past(err_req))) |=> !err_armed); // R7

endmodule

// File: tb/ami_violation_encoder_tb.sv
module ami_violation_encoder_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic data_in = 1'b0;
    logic viol_req = 1'b0;
    logic err_req = 1'b0;
    logic rail_pos;
    logic rail_neg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic m0 = 1'b0, m1 = 1'b0, m2 = 1'b0;
    logic last_pos = 1'b0;
    logic vpend = 1'b0, epend = 1'b0;
    logic exp_pos = 1'b0, exp_neg = 1'b0;
    string exp_tag = "R1";

    always #10 clk = ~clk;

    ami_violation_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
        .viol_req(viol_req), .err_req(err_req),
        .rail_pos(rail_pos), .rail_neg(rail_neg)
    );

    task automatic check(input string tag, input logic ap, input logic an,
                         input logic ep, input logic en);
        total++;
        if (ap !== ep || an !== en) begin
            bad++;
            $display("FAIL %s: rails pos/neg=%b%b expected %b%b at %0t",
                     tag, ap, an, ep, en, $time);
        end
    endtask

    // expected rails for the bit two periods back (R1 R2 R4 R5)
    function automatic void model_bit(input logic b);
        logic eb, pol;
        eb = b ^ epend;
        epend = 1'b0;
        if (!m1) begin
            exp_pos = 1'b0; exp_neg = 1'b0; exp_tag = "R1";
        end else begin
            if (vpend && m0 && m2) begin
                pol = last_pos; vpend = 1'b0; exp_tag = "R4";
            end else begin
                pol = ~last_pos; exp_tag = "R2/R5";
            end
            last_pos = pol;
            exp_pos = pol; exp_neg = ~pol;
        end
        m2 = m1; m1 = m0; m0 = eb;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1; data_in = b;
        @(negedge clk);
        bit_en = 1'b0; data_in = $urandom_range(0, 1);
        model_bit(b);
        check(exp_tag, rail_pos, rail_neg, exp_pos, exp_neg);
        check("R9", rail_pos & rail_neg, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3", rail_pos, rail_neg, exp_pos, exp_neg);
    endtask

    task automatic pulse_viol();
        @(negedge clk); viol_req = 1'b1;
        @(negedge clk); viol_req = 1'b0;
        vpend = 1'b1;
    endtask

    task automatic pulse_err();
        @(negedge clk); err_req = 1'b1;
        @(negedge clk); err_req = 1'b0;
        epend = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(negedge clk);
        check("R10", rail_pos, rail_neg, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", rail_pos, rail_neg, 1'b0, 1'b0);

        // R2: first mark positive, then alternation; R3 latency
        send_bit(1'b1);
        send_bit(1'b0);
        check("R3", rail_pos, rail_neg, 1'b0, 1'b0);
        send_bit(1'b0);
        check("R3", rail_pos, rail_neg, 1'b1, 1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);

        // R4: armed during zeros, isolated ones and pairs do not fire
        pulse_viol();
        for (int i = 0; i < 2; i++) send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0);

        // R6: level held high across several runs gives one violation
        @(negedge clk); viol_req = 1'b1; vpend = 1'b1;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 4; i++) send_bit(1'b1);
            send_bit(1'b0);
        end
        @(negedge clk); viol_req = 1'b0;
        send_bit(1'b0); send_bit(1'b0);

        // R7: error flips a zero to complete a run; R5 after it
        pulse_viol();
        send_bit(1'b1);
        pulse_err();
        send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);

        // R8: held err_req inverts only one bit
        @(negedge clk); err_req = 1'b1; epend = 1'b1;
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        @(negedge clk); err_req = 1'b0;
        send_bit(1'b0); send_bit(1'b0);

        // random traffic with sparse requests
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 19) == 0) pulse_viol();
            if ($urandom_range(0, 29) == 0) pulse_err();
            send_bit(logic'($urandom_range(0, 2) != 0));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule